// File: doc/BRIEF.md
# External Trigger Input/Output Unit

This block sits between an acquisition sequencer and outside equipment. A single asynchronous trigger pin is brought into the fast clock domain, looked at only on a slow microsecond enable tick, and turned into a one-shot "arm" that permits the sequencer to start its next send/receive activity. When external gating is switched off the sequencer is always allowed to proceed.

In the other direction, every start the sequencer reports can launch an output trigger pulse. The pulse is timed in whole cycles of the fast clock, and its length comes from a width setting. A mode input selects whether each individual event produces a pulse, or only the first event of a sequence does. A start that arrives while a pulse is still running does not stretch or restart it.

Top module: `trig_io_unit`

## Requirements
- R1: The trigger pin passes through a two-stage synchronizer and is sampled only in cycles where `tick_us` is 1; a high level that appears and vanishes between two ticks is never seen.
- R2: A trigger is a sample of 1 following a sample of 0; it sets the internal arm. A level held high across further ticks does not set the arm again.
- R3: With `cfg_gate_en` = 0, `go` is 1 and the arm is held clear. With `cfg_gate_en` = 1, `go` equals the arm.
- R4: A counted start accepted while `go` = 1 and gating is on clears the arm at the next clock edge. A counted start seen while `go` = 0 produces no pulse and leaves the arm unchanged.
- R5: An accepted counted start with a nonzero width raises `trig_out` in the cycle after the strobe, for exactly `cfg_width` clock cycles.
- R6: A width value of 0 produces no output pulse.
- R7: With `cfg_per_seq` = 0 every `evt_start` is counted; with `cfg_per_seq` = 1 only a strobe with `evt_first` = 1 is counted, and other strobes touch neither the pulse nor the arm.
- R8: A start strobe that arrives while `trig_out` is high is ignored: the running pulse keeps its length and no second pulse follows.
- R9: After reset `trig_out` is 0, the arm is clear, and the stored tick sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock (output pulse resolution) |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle enable at the input sampling rate |
| cfg_gate_en | input | 1 | 1 = starts wait for an external trigger |
| cfg_per_seq | input | 1 | 1 = pulse/arm only on first event of a sequence |
| cfg_width | input | PW | Output pulse length in clock cycles, 0 = off |
| evt_start | input | 1 | One-cycle strobe: sequencer starts an event |
| evt_first | input | 1 | Qualifies `evt_start` as first event of a sequence |
| trig_in | input | 1 | Asynchronous external trigger pin |
| go | output | 1 | Permission for the sequencer to start |
| trig_out | output | 1 | External trigger output pulse |

## Verification
A stuck or stale arm shows up on `go` within one clock of the tick or start that should have changed it, so every gating scenario is checked on `go` right after the relevant edge. A wrong pulse counter shows on `trig_out` as an early, late, short or long pulse, measured by counting high cycles from the cycle after the strobe. Missed or doubled edge detection appears as `go` staying low after a fresh trigger or rising again under a held-high input, both visible one tick later.

// File: rtl/trig_io_pkg.sv
package trig_io_pkg;

    // state of the synchronizer chain
    typedef struct packed {
        logic [1:0] sh;
    } sync_st_t;

    // state of the tick sampler
    typedef struct packed {
        logic samp;
    } samp_st_t;

    // state of the top-level gating logic
    typedef struct packed {
        logic armed;
    } gate_st_t;

endpackage

// File: rtl/trig_in_sync.sv
module trig_in_sync
    import trig_io_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.sh[1];
endmodule

// File: rtl/trig_edge_sampler.sv
module trig_edge_sampler
    import trig_io_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lvl,
    output logic edge_o
);
    samp_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        edge_o = 1'b0;
        if (tick) begin
            st_d.samp = lvl;
            edge_o    = lvl & ~st_q.samp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [PW-1:0] width,
    output logic          pulse
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } pg_st_t;

    pg_st_t st_d, st_q;
    logic   busy;

    assign busy = (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (fire && !busy && width != '0) begin
            st_d.cnt = width;
        end else if (busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = busy;
endmodule

// File: rtl/trig_io_unit.sv
module trig_io_unit
    import trig_io_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_us,
    input  logic          cfg_gate_en,
    input  logic          cfg_per_seq,
    input  logic [PW-1:0] cfg_width,
    input  logic          evt_start,
    input  logic          evt_first,
    input  logic          trig_in,
    output logic          go,
    output logic          trig_out
);
    logic     trig_sync;
    logic     edge_det;
    logic     counted;
    logic     launch;
    gate_st_t st_d, st_q;

    trig_in_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (trig_in),
        .dout (trig_sync)
    );

    trig_edge_sampler u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_us),
        .lvl   (trig_sync),
        .edge_o(edge_det)
    );

    always_comb begin
        counted = evt_start & (~cfg_per_seq | evt_first);
        go      = ~cfg_gate_en | st_q.armed;
        launch  = counted & go;
        st_d    = st_q;
        if (!cfg_gate_en) begin
            st_d.armed = 1'b0;
        end else if (edge_det) begin
            st_d.armed = 1'b1;
        end else if (launch) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    trig_pulse_gen #(.PW(PW)) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (launch),
        .width(cfg_width),
        .pulse(trig_out)
    );
endmodule

// File: rtl/trig_io_unit_chk.sv
module trig_io_unit_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_us,
    input logic          cfg_gate_en,
    input logic          cfg_per_seq,
    input logic [PW-1:0] cfg_width,
    input logic          evt_start,
    input logic          evt_first,
    input logic          edge_det,
    input logic          armed,
    input logic          go,
    input logic          trig_out
);
    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |-> tick_us); // R1

    AST_NO_GATE_GO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_gate_en |-> go); // R3

    AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gate_en && go && evt_start && (!cfg_per_seq || evt_first) && !edge_det) |=> !armed); // R4

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && evt_start && (!cfg_per_seq || evt_first) && !trig_out && cfg_width != '0) |=> trig_out); // R5

    AST_ROSE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> $past(evt_start && go)); // R5

    AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_out && cfg_width == '0) |=> !trig_out); // R6

    AST_PER_SEQ_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_per_seq && evt_start && !evt_first && !trig_out) |=> !trig_out); // R7
endmodule

bind trig_io_unit trig_io_unit_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_us    (tick_us),
    .cfg_gate_en(cfg_gate_en),
    .cfg_per_seq(cfg_per_seq),
    .cfg_width  (cfg_width),
    .evt_start  (evt_start),
    .evt_first  (evt_first),
    .edge_det   (edge_det),
    .armed      (st_q.armed),
    .go         (go),
    .trig_out   (trig_out)
);

// File: tb/trig_io_unit_bench.sv
module trig_io_unit_bench;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_us = 1'b0;
    logic          cfg_gate_en = 1'b0;
    logic          cfg_per_seq = 1'b0;
    logic [PW-1:0] cfg_width = '0;
    logic          evt_start = 1'b0;
    logic          evt_first = 1'b0;
    logic          trig_in = 1'b0;
    logic          go;
    logic          trig_out;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    trig_io_unit #(.PW(PW)) u_trig_io_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_us    (tick_us),
        .cfg_gate_en(cfg_gate_en),
        .cfg_per_seq(cfg_per_seq),
        .cfg_width  (cfg_width),
        .evt_start  (evt_start),
        .evt_first  (evt_first),
        .trig_in    (trig_in),
        .go         (go),
        .trig_out   (trig_out)
    );

    typedef struct packed {
        logic [7:0]  w;
        logic        per_seq;
        logic        first;
        logic [15:0] exp_len;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{w: 8'd5,   per_seq: 1'b0, first: 1'b0, exp_len: 16'd5},   // R5
        '{w: 8'd1,   per_seq: 1'b0, first: 1'b0, exp_len: 16'd1},   // R5
        '{w: 8'd0,   per_seq: 1'b0, first: 1'b0, exp_len: 16'd0},   // R6
        '{w: 8'd3,   per_seq: 1'b1, first: 1'b1, exp_len: 16'd3},   // R7
        '{w: 8'd3,   per_seq: 1'b1, first: 1'b0, exp_len: 16'd0},   // R7
        '{w: 8'd7,   per_seq: 1'b0, first: 1'b1, exp_len: 16'd7},   // R7
        '{w: 8'd255, per_seq: 1'b0, first: 1'b0, exp_len: 16'd255}  // R5
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic first);
        @(negedge clk);
        evt_start = 1'b1;
        evt_first = first;
        @(negedge clk);
        evt_start = 1'b0;
        evt_first = 1'b0;
    endtask

    task automatic measure(output int len);
        len = 0;
        repeat (300) begin
            if (trig_out) len++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_us = 1'b1;
        @(negedge clk);
        tick_us = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len;
        // reset state, R9
        wait_cyc(3);
        chk("R9 trig_out in reset", int'(trig_out), 0);
        chk("R3 go with gating off", int'(go), 1);
        rst_n = 1'b1;
        wait_cyc(2);
        cfg_gate_en = 1'b1;
        wait_cyc(1);
        chk("R9 arm clear after reset", int'(go), 0);
        cfg_gate_en = 1'b0;
        wait_cyc(1);

        // table of width / mode cases with gating off
        foreach (VECS[i]) begin
            cfg_width   = VECS[i].w;
            cfg_per_seq = VECS[i].per_seq;
            strobe(VECS[i].first);
            measure(len);
            chk($sformatf("R5/R6/R7 vector %0d pulse length", i), len, int'(VECS[i].exp_len));
        end

        // gating
        cfg_per_seq = 1'b0;
        cfg_width   = 8'd4;
        cfg_gate_en = 1'b1;
        wait_cyc(2);
        chk("R3 go low while unarmed", int'(go), 0);
        trig_in = 1'b1;
        wait_cyc(6);
        chk("R1 no arm without tick", int'(go), 0);
        pulse_tick();
        chk("R2 rising edge arms", int'(go), 1);
        strobe(1'b0);
        chk("R4 start clears arm", int'(go), 0);
        measure(len);
        chk("R5 gated pulse length", len, 4);
        pulse_tick();
        chk("R2 held high does not rearm", int'(go), 0);
        strobe(1'b0);
        measure(len);
        chk("R4 start while go low gives no pulse", len, 0);
        trig_in = 1'b0;
        wait_cyc(3);
        pulse_tick();
        trig_in = 1'b1;
        wait_cyc(3);
        pulse_tick();
        chk("R2 new edge arms", int'(go), 1);

        // per-sequence mode with gating
        cfg_per_seq = 1'b1;
        strobe(1'b0);
        chk("R7 non-first start keeps arm", int'(go), 1);
        measure(len);
        chk("R7 non-first start no pulse", len, 0);
        strobe(1'b1);
        chk("R7 first start consumes arm", int'(go), 0);
        measure(len);
        chk("R7 first start pulse", len, 4);

        // short high between ticks is missed
        trig_in = 1'b0;
        wait_cyc(3);
        pulse_tick();
        trig_in = 1'b1;
        wait_cyc(4);
        trig_in = 1'b0;
        wait_cyc(4);
        pulse_tick();
        chk("R1 glitch between ticks unseen", int'(go), 0);

        // disabling gating clears arm
        trig_in = 1'b1;
        wait_cyc(3);
        pulse_tick();
        chk("R2 armed before disable", int'(go), 1);
        cfg_gate_en = 1'b0;
        wait_cyc(1);
        cfg_gate_en = 1'b1;
        wait_cyc(1);
        chk("R3 disable clears arm", int'(go), 0);

        // start during active pulse ignored
        cfg_gate_en = 1'b0;
        cfg_per_seq = 1'b0;
        cfg_width   = 8'd10;
        strobe(1'b0);
        len = 0;
        for (int i = 0; i < 30; i++) begin
            if (trig_out) len++;
            evt_start = (i == 3);
            @(negedge clk);
        end
        evt_start = 1'b0;
        chk("R8 restart ignored during pulse", len, 10);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule